// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line priority controllers, one master and one slave, into a sixteen-line interrupt source for a processor. The slave's request is forwarded into the master on cascade input 2. When the processor strobes `ack`, the block finds the winning line and updates the pending and in-service state of the master, and of the slave too when the cascade line wins. One cycle later it presents an 8-bit vector. If a controller has nothing to give, the vector reports spurious line 7 for that controller.

A poll read path lets software ask either controller for its winner without a vector cycle. The winner is reported with bit 7 set, or as 0x07 when no request is waiting. Programming values such as vector bases, masks, trigger modes and the automatic end-of-interrupt options arrive as static inputs. Register access is out of scope. Bits 7:0 of every 16-bit line vector belong to the master and bits 15:8 to the slave.

Top module: `pic_cascade_ack`

## Requirements
- R1: While `rst_n` is sampled low, all pending, in-service and rotation state clears. After reset `int_out`, `vec_valid` and `poll_valid` are low.
- R2: A line with its `level_sel` bit at 0 becomes pending on a sampled 0-to-1 transition and stays pending after the line falls. A line with its `level_sel` bit at 1 is pending exactly while it was high at the last edge.
- R3: `int_out` is high when the master's best unmasked pending line (mask bit 1 = masked) ranks above every in-service line. Rank runs upward from the rotation base (reset 0) modulo 8, and the lowest rank wins.
- R4: `vec_valid` is high for exactly the cycle after each cycle in which `ack` is sampled high. `vec_out` is {base[4:0], line[2:0]}.
- R5: If the master has no valid request at acknowledge, `vec_out` = {master_vbase, 3'd7} and no state changes.
- R6: If the master winner is a line other than 2, `vec_out` = {master_vbase, line}. The line's pending bit clears if it is edge-triggered and is kept if it is level-triggered.
- R7: If the master winner is line 2, the slave is acknowledged too and `vec_out` = {slave_vbase, slave line}. If the slave has no valid request, `vec_out` = {slave_vbase, 3'd7}.
- R8: On an acknowledged controller with `auto_eoi` set, no in-service bit is set. If `rotate_aeoi` is also set, the rotation base becomes line+1 modulo 8. Without `auto_eoi`, the winner's in-service bit is set and it blocks equal and lower ranks.
- R9: In every cycle where the slave has a valid request and neither `ack` nor `poll_req` is high, master pending bit 2 is set. Master external line 2 and its level select are ignored.
- R10: A poll sampled without `ack` gives `poll_valid` the next cycle, with `poll_data` = 0x80|line, or 0x07 if there is no winner. The polled controller's winner has its edge-triggered pending bit and its in-service bit cleared. A slave poll with a winner also clears master pending and in-service bit 2.
- R11: When `ack` and `poll_req` are sampled together, the acknowledge is served and the poll is dropped: `poll_valid` stays low and no poll clearing happens.
- R12: A new rising edge on an edge-triggered line in the same cycle that acknowledges it leaves that line pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 16 | Request lines, 7:0 master, 15:8 slave |
| level_sel | input | 16 | 1 = level-triggered, 0 = edge-triggered |
| irq_mask | input | 16 | 1 = line masked |
| master_vbase | input | 5 | Master vector base, bits 7:3 of its vectors |
| slave_vbase | input | 5 | Slave vector base, bits 7:3 of its vectors |
| auto_eoi | input | 2 | Automatic end of interrupt, bit 0 master, bit 1 slave |
| rotate_aeoi | input | 2 | Rotate on automatic end of interrupt, bit 0 master, bit 1 slave |
| ack | input | 1 | Processor acknowledge strobe |
| poll_req | input | 1 | Poll read strobe |
| poll_sel | input | 1 | Poll target, 0 master, 1 slave |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Acknowledge vector |
| vec_valid | output | 1 | Vector valid, one cycle after `ack` |
| poll_data | output | 8 | Poll result |
| poll_valid | output | 1 | Poll result valid |

## Verification
Three things can land on the same clock edge: an acknowledge, a poll, and the request edges and cascade forwarding that set pending bits. Directed cases raise `ack` and `poll_req` together to show that only the vector appears. They also bring a fresh rising edge onto the line being acknowledged, so a second acknowledge must return the same line. Random stimulus raises all three strobes and line toggles freely over varied trigger, mask and end-of-interrupt settings. A bench model computes the vector, the poll result and `int_out` for each cycle, and the outputs are compared against it.

// File: rtl/pic_cas_pkg.sv
// Package: shared sizes and the per-controller command bundle for the
// cascaded acknowledge sequencer. Assumes power-of-two line counts.
package pic_cas_pkg;
    localparam int DEF_LINES = 8;
    localparam int DEF_VEC_W = 8;
    localparam int DEF_CASC  = 2;

    // Commands the sequencer issues to one controller core in a cycle.
    typedef struct packed {
        logic ack;   // acknowledge own winner
        logic poll;  // poll read of own winner
        logic drop;  // clear pending and in-service of the cascade line
        logic casc;  // cascade forward: set pending on the cascade line
    } core_cmd_t;
endpackage

// File: rtl/pic_prio.sv
// Priority resolver: finds the best pending line with rotated ranking and
// compares it against the best in-service line. Purely combinational.
// Assumes LINES is a power of two so the rotated index wraps naturally.
module pic_prio #(
    parameter int LINES = 8,
    parameter int LW    = $clog2(LINES)
) (
    input  logic [LINES-1:0] pend,
    input  logic [LINES-1:0] inserv,
    input  logic [LW-1:0]    base,
    output logic             valid,
    output logic [LW-1:0]    line
);
    logic [LW:0]   req_rank;
    logic [LW:0]   cur_rank;
    logic [LW-1:0] idx;

    // Scan ranks from lowest priority upward so the smallest rank survives.
    always_comb begin
        req_rank = (LW+1)'(LINES);
        cur_rank = (LW+1)'(LINES);
        idx      = '0;
        for (int p = LINES - 1; p >= 0; p--) begin
            idx = base + LW'(p);
            if (pend[idx])   req_rank = (LW+1)'(p);
            if (inserv[idx]) cur_rank = (LW+1)'(p);
        end
        valid = (req_rank < cur_rank);
        line  = base + req_rank[LW-1:0];
    end
endmodule

// File: rtl/pic_core.sv
// Controller core: holds pending, in-service, last-level and rotation
// state for one controller and applies acknowledge, poll and cascade
// commands. Assumes the sequencer never issues ack and poll together.
// With HAS_CASC set, line CASC_LINE is fed only by the cascade command.
module pic_core
    import pic_cas_pkg::*;
#(
    parameter int LINES     = DEF_LINES,
    parameter int LW        = $clog2(LINES),
    parameter bit HAS_CASC  = 1'b0,
    parameter int CASC_LINE = DEF_CASC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] lvl_sel,
    input  logic [LINES-1:0] mask,
    input  logic             aeoi,
    input  logic             rot_aeoi,
    input  core_cmd_t        cmd,
    output logic             win_valid,
    output logic [LW-1:0]    win_line,
    output logic [LINES-1:0] irr_o,
    output logic [LINES-1:0] isr_o
);
    localparam logic [LINES-1:0] CMASK =
        HAS_CASC ? (LINES'(1) << CASC_LINE) : '0;

    logic [LINES-1:0] irr_q, isr_q, last_q;
    logic [LW-1:0]    rot_q, rot_d;
    logic [LINES-1:0] src, lvl_eff, win_oh;
    logic [LINES-1:0] clr_irr, clr_isr, set_isr, edge_irr, irr_d, isr_d;

    pic_prio #(.LINES(LINES), .LW(LW)) u_prio (
        .pend   (irr_q & ~mask),
        .inserv (isr_q),
        .base   (rot_q),
        .valid  (win_valid),
        .line   (win_line)
    );

    // External lines with the cascade input removed from them.
    assign src     = line_in & ~CMASK;
    assign lvl_eff = lvl_sel & ~CMASK;
    assign win_oh  = (LINES'(1) << win_line) & {LINES{win_valid}};

    // Next-state: command clears, then trigger sets (sets win over clears).
    always_comb begin
        clr_irr = '0;
        clr_isr = '0;
        set_isr = '0;
        rot_d   = rot_q;
        if (cmd.ack) begin
            clr_irr = win_oh & ~lvl_eff;
            if (aeoi) begin
                if (rot_aeoi && win_valid) rot_d = win_line + LW'(1);
            end else begin
                set_isr = win_oh;
            end
        end
        if (cmd.poll) begin
            clr_irr = clr_irr | win_oh;
            clr_isr = clr_isr | win_oh;
        end
        if (cmd.drop) begin
            clr_irr = clr_irr | CMASK;
            clr_isr = clr_isr | CMASK;
        end
        edge_irr = (irr_q & ~clr_irr) | (src & ~last_q) | (CMASK & {LINES{cmd.casc}});
        irr_d    = (lvl_eff & src) | (~lvl_eff & edge_irr);
        isr_d    = (isr_q & ~clr_isr) | set_isr;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= '0;
            isr_q  <= '0;
            last_q <= '0;
            rot_q  <= '0;
        end else begin
            irr_q  <= irr_d;
            isr_q  <= isr_d;
            last_q <= src;
            rot_q  <= rot_d;
        end
    end

    assign irr_o = irr_q;
    assign isr_o = isr_q;
endmodule

// File: rtl/pic_cascade_ack.sv
// Cascaded acknowledge sequencer: joins a master and a slave core, forwards
// slave requests onto the master cascade line, resolves acknowledges into a
// vector (with spurious handling) and serves poll reads.
// Assumes programming inputs are quasi-static; ack takes priority over poll.
module pic_cascade_ack
    import pic_cas_pkg::*;
#(
    parameter int LINES     = DEF_LINES,
    parameter int VEC_W     = DEF_VEC_W,
    parameter int CASC_LINE = DEF_CASC,
    parameter int LW        = $clog2(LINES),
    parameter int VB_W      = VEC_W - LW,
    parameter int ALL       = 2 * LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ALL-1:0]   irq_lines,
    input  logic [ALL-1:0]   level_sel,
    input  logic [ALL-1:0]   irq_mask,
    input  logic [VB_W-1:0]  master_vbase,
    input  logic [VB_W-1:0]  slave_vbase,
    input  logic [1:0]       auto_eoi,
    input  logic [1:0]       rotate_aeoi,
    input  logic             ack,
    input  logic             poll_req,
    input  logic             poll_sel,
    output logic             int_out,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic [VEC_W-1:0] poll_data,
    output logic             poll_valid
);
    localparam logic [LW-1:0] SPUR = {LW{1'b1}};
    localparam logic [LW-1:0] CASC = LW'(CASC_LINE);

    logic [1:0]                  c_valid;
    logic [1:0][LW-1:0]          c_line;
    logic [1:0][LINES-1:0]       c_irr, c_isr;
    core_cmd_t [1:0]             c_cmd;
    logic                        do_poll;
    logic [VEC_W-1:0]            vec_d, poll_d;

    // One core per controller; index 0 is the master with the cascade input.
    for (genvar g = 0; g < 2; g++) begin : g_core
        pic_core #(
            .LINES(LINES), .LW(LW), .HAS_CASC(g == 0), .CASC_LINE(CASC_LINE)
        ) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_in   (irq_lines[g*LINES +: LINES]),
            .lvl_sel   (level_sel[g*LINES +: LINES]),
            .mask      (irq_mask[g*LINES +: LINES]),
            .aeoi      (auto_eoi[g]),
            .rot_aeoi  (rotate_aeoi[g]),
            .cmd       (c_cmd[g]),
            .win_valid (c_valid[g]),
            .win_line  (c_line[g]),
            .irr_o     (c_irr[g]),
            .isr_o     (c_isr[g])
        );
    end

    // Command decode: ack first, poll only when no ack, cascade otherwise.
    always_comb begin
        do_poll       = poll_req & ~ack;
        c_cmd[0].ack  = ack;
        c_cmd[1].ack  = ack & c_valid[0] & (c_line[0] == CASC) & c_valid[1];
        c_cmd[0].poll = do_poll & ~poll_sel;
        c_cmd[1].poll = do_poll & poll_sel;
        c_cmd[0].drop = do_poll & poll_sel & c_valid[1];
        c_cmd[1].drop = 1'b0;
        c_cmd[0].casc = c_valid[1] & ~ack & ~do_poll;
        c_cmd[1].casc = 1'b0;
    end

    // Vector selection including spurious cases on either controller.
    always_comb begin
        if (!c_valid[0])
            vec_d = {master_vbase, SPUR};
        else if (c_line[0] == CASC)
            vec_d = c_valid[1] ? {slave_vbase, c_line[1]} : {slave_vbase, SPUR};
        else
            vec_d = {master_vbase, c_line[0]};
    end

    // Poll result for the selected controller.
    always_comb begin
        if (c_valid[poll_sel])
            poll_d = {1'b1, {(VEC_W-1-LW){1'b0}}, c_line[poll_sel]};
        else
            poll_d = VEC_W'(SPUR);
    end

    // Output registers: vector and poll results valid one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out    <= '0;
            vec_valid  <= 1'b0;
            poll_data  <= '0;
            poll_valid <= 1'b0;
        end else begin
            vec_valid  <= ack;
            poll_valid <= do_poll;
            if (ack)     vec_out   <= vec_d;
            if (do_poll) poll_data <= poll_d;
        end
    end

    assign int_out = c_valid[0];
endmodule

// File: rtl/pic_cascade_ack_chk.sv
// Checker for the cascaded acknowledge sequencer, bound to the top module.
// Observes ports and the per-core winner/state buses.
module pic_cascade_ack_chk #(
    parameter int LINES     = 8,
    parameter int LW        = 3,
    parameter int VB_W      = 5,
    parameter int CASC_LINE = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ack,
    input logic                  poll_req,
    input logic                  poll_sel,
    input logic [1:0]            auto_eoi,
    input logic [VB_W-1:0]       master_vbase,
    input logic [VB_W-1:0]       slave_vbase,
    input logic                  int_out,
    input logic [VB_W+LW-1:0]    vec_out,
    input logic                  vec_valid,
    input logic                  poll_valid,
    input logic [1:0]            c_valid,
    input logic [1:0][LW-1:0]    c_line,
    input logic [1:0][LINES-1:0] c_irr,
    input logic [1:0][LINES-1:0] c_isr
);
    localparam logic [LW-1:0] CASC = LW'(CASC_LINE);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!vec_valid && !poll_valid && !int_out));

    assert_vec_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);

    assert_vec_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_valid);

    assert_spurious_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !c_valid[0]) |=> vec_out == {$past(master_vbase), {LW{1'b1}}});

    assert_master_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && c_valid[0] && c_line[0] != CASC)
        |=> vec_out == {$past(master_vbase), $past(c_line[0])});

    assert_slave_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && c_valid[0] && c_line[0] == CASC && c_valid[1])
        |=> vec_out == {$past(slave_vbase), $past(c_line[1])});

    assert_aeoi_keeps_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && c_valid[0] && auto_eoi[0]) |=> c_isr[0] == $past(c_isr[0]));

    assert_nested_sets_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && c_valid[0] && !auto_eoi[0]) |=> c_isr[0][$past(c_line[0])]);

    assert_cascade_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_valid[1] && !ack && !poll_req) |=> c_irr[0][CASC_LINE]);

    assert_poll_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !ack) |=> poll_valid);

    assert_slave_poll_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !ack && poll_sel && c_valid[1])
        |=> (!c_isr[0][CASC_LINE] && !c_isr[1][$past(c_line[1])]));

    assert_ack_beats_poll_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && poll_req) |=> !poll_valid);
endmodule

bind pic_cascade_ack pic_cascade_ack_chk #(
    .LINES(LINES), .LW(LW), .VB_W(VB_W), .CASC_LINE(CASC_LINE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack          (ack),
    .poll_req     (poll_req),
    .poll_sel     (poll_sel),
    .auto_eoi     (auto_eoi),
    .master_vbase (master_vbase),
    .slave_vbase  (slave_vbase),
    .int_out      (int_out),
    .vec_out      (vec_out),
    .vec_valid    (vec_valid),
    .poll_valid   (poll_valid),
    .c_valid      (c_valid),
    .c_line       (c_line),
    .c_irr        (c_irr),
    .c_isr        (c_isr)
);

// File: tb/tb_pic_cascade_ack.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a behavioural model written from the requirements.
module tb_pic_cascade_ack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lines = '0, lvl = '0, msk = '0;
    logic [4:0]  mvb = 5'd4, svb = 5'd14;
    logic [1:0]  aeoi = 2'b11, raeoi = 2'b00;
    logic        ack = 1'b0, preq = 1'b0, psel = 1'b0;
    logic        int_out, vec_valid, poll_valid;
    logic [7:0]  vec_out, poll_data;

    int checks = 0, fails = 0;
    string cur_tag = "R1";

    // model state
    logic [7:0] r_irr [2], r_isr [2], r_lst [2];
    logic [2:0] r_rot [2];
    logic       e_int = 1'b0, e_vv = 1'b0, e_pv = 1'b0;
    logic [7:0] e_vec = '0, e_pd = '0;
    string      e_vtag = "R4", e_ptag = "R10";

    always #5 clk = ~clk;

    pic_cascade_ack dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .level_sel(lvl),
        .irq_mask(msk), .master_vbase(mvb), .slave_vbase(svb),
        .auto_eoi(aeoi), .rotate_aeoi(raeoi), .ack(ack), .poll_req(preq),
        .poll_sel(psel), .int_out(int_out), .vec_out(vec_out),
        .vec_valid(vec_valid), .poll_data(poll_data), .poll_valid(poll_valid)
    );

    function automatic int rank(logic [7:0] p, logic [2:0] b);
        for (int i = 0; i < 8; i++) if (p[(int'(b) + i) % 8]) return i;
        return 8;
    endfunction

    function automatic void winner(int c, output bit v, output int l);
        int r, cur;
        r   = rank(r_irr[c] & ~msk[c*8 +: 8], r_rot[c]);
        cur = rank(r_isr[c], r_rot[c]);
        v   = (r < 8) && (r < cur);
        l   = (r + int'(r_rot[c])) % 8;
    endfunction

    function automatic bit is_lvl(int c, int i);
        return (c == 0 && i == 2) ? 1'b0 : lvl[c*8 + i];
    endfunction

    // Advance the model by one clock edge using the currently driven inputs.
    task automatic model_step();
        bit mv, sv, pv, acked, do_poll, cset, src, casc;
        int ml, sl, pl, l;
        logic [7:0] ci, cs, ss;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                r_irr[c] = '0; r_isr[c] = '0; r_lst[c] = '0; r_rot[c] = '0;
            end
            e_vv = 0; e_pv = 0; e_int = 0;
            return;
        end
        winner(0, mv, ml);
        winner(1, sv, sl);
        do_poll = preq && !ack;
        e_vv = ack;
        if (ack) begin
            if (!mv) begin e_vec = {mvb, 3'd7}; e_vtag = "R5"; end
            else if (ml == 2) begin
                e_vec = sv ? {svb, 3'(sl)} : {svb, 3'd7}; e_vtag = "R7";
            end else begin e_vec = {mvb, 3'(ml)}; e_vtag = "R6"; end
        end
        e_pv = do_poll;
        e_ptag = (preq && ack) ? "R11" : "R10";
        if (do_poll) begin
            winner(int'(psel), pv, pl);
            e_pd = pv ? (8'h80 | 8'(pl)) : 8'h07;
        end
        cset = sv && !ack && !do_poll;
        for (int c = 0; c < 2; c++) begin
            ci = '0; cs = '0; ss = '0;
            acked = (c == 0) ? (ack && mv) : (ack && mv && ml == 2 && sv);
            l = (c == 0) ? ml : sl;
            if (acked) begin
                if (!is_lvl(c, l)) ci[l] = 1'b1;
                if (aeoi[c]) begin if (raeoi[c]) r_rot[c] = 3'(l + 1); end
                else ss[l] = 1'b1;
            end
            if (do_poll && int'(psel) == c && ((c == 0) ? mv : sv)) begin
                ci[l] = 1'b1; cs[l] = 1'b1;
            end
            if (c == 0 && do_poll && psel && sv) begin ci[2] = 1'b1; cs[2] = 1'b1; end
            for (int i = 0; i < 8; i++) begin
                casc = (c == 0 && i == 2);
                src  = casc ? 1'b0 : lines[c*8 + i];
                if (is_lvl(c, i)) r_irr[c][i] = src;
                else r_irr[c][i] = (r_irr[c][i] & ~ci[i]) | (src & ~r_lst[c][i]) | (casc & cset);
                r_lst[c][i] = src;
            end
            r_isr[c] = (r_isr[c] & ~cs) | ss;
        end
        winner(0, mv, ml);
        e_int = mv;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (%s) at %0t: actual=0x%0h expected=0x%0h", tag, cur_tag, $time, act, exp);
        end
    endtask

    // Compare all outputs, sampled at the falling edge.
    task automatic compare();
        check(int_out == e_int, "R3", int_out, e_int);
        check(vec_valid == e_vv, "R4", vec_valid, e_vv);
        if (e_vv) check(vec_out == e_vec, e_vtag, vec_out, e_vec);
        check(poll_valid == e_pv, e_ptag, poll_valid, e_pv);
        if (e_pv) check(poll_data == e_pd, "R10", poll_data, e_pd);
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; lines = '0; ack = 0; preq = 0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic pulse(int i);
        lines[i] = 1'b1; tick(); lines[i] = 1'b0; tick();
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_poll_rd(bit sel);
        preq = 1'b1; psel = sel; tick(); preq = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0417);
        // R1: reset state, then ack with nothing pending (R5)
        cur_tag = "R1"; do_reset(); tick();
        check(int_out == 0 && vec_valid == 0 && poll_valid == 0, "R1", int_out, 0);
        cur_tag = "R5"; do_ack(); tick();
        // R2/R6: edge line pending after it falls, cleared by ack
        cur_tag = "R2"; do_reset(); pulse(5); tick();
        cur_tag = "R6"; do_ack(); tick(); do_ack(); tick();
        // R6: level line stays pending across acknowledge
        cur_tag = "R6"; do_reset(); lvl[4] = 1; lines[4] = 1; tick();
        do_ack(); do_ack(); lines[4] = 0; lvl[4] = 0; tick(); tick();
        // R7/R9: slave request reaches master via cascade line
        cur_tag = "R9"; do_reset(); pulse(11); tick();
        cur_tag = "R7"; do_ack(); tick();
        // R7: slave spurious when its request vanishes after forwarding
        do_reset(); pulse(9); msk[9] = 1; tick(); do_ack(); tick(); msk[9] = 0;
        // R8: rotate on automatic end of interrupt
        cur_tag = "R8"; raeoi = 2'b01; do_reset(); pulse(1); pulse(6);
        do_ack(); pulse(0); do_ack(); do_ack(); tick(); raeoi = 2'b00;
        // R8: nested mode, in-service blocks lower ranks
        aeoi = 2'b00; do_reset(); pulse(3); do_ack(); pulse(5); tick();
        pulse(1); do_ack(); tick(); aeoi = 2'b11;
        // R10: master and slave poll reads
        cur_tag = "R10"; do_reset(); pulse(6); do_poll_rd(0); do_poll_rd(0);
        pulse(10); tick(); do_poll_rd(1); tick(); do_poll_rd(1);
        // R11: ack and poll in the same cycle
        cur_tag = "R11"; do_reset(); pulse(4); preq = 1; psel = 0; do_ack(); preq = 0; tick();
        // R12: new edge on the acknowledged line keeps it pending
        cur_tag = "R12"; do_reset(); pulse(5);
        lines[5] = 1; do_ack(); lines[5] = 0; tick(); do_ack(); tick();
        // Random phases (R2, R3 and everything else through the model)
        cur_tag = "R3";
        for (int ph = 0; ph < 30; ph++) begin
            lvl = 16'($urandom) & 16'($urandom);
            msk = 16'($urandom) & 16'($urandom) & 16'($urandom);
            aeoi = 2'($urandom); raeoi = 2'($urandom);
            mvb = 5'($urandom); svb = 5'($urandom);
            do_reset();
            for (int cy = 0; cy < 80; cy++) begin
                for (int b = 0; b < 16; b++) if ($urandom_range(0, 7) == 0) lines[b] = ~lines[b];
                ack  = ($urandom_range(0, 4) == 0);
                preq = ($urandom_range(0, 5) == 0);
                psel = 1'($urandom);
                tick();
            end
            ack = 0; preq = 0;
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule